// File: doc/BRIEF.md
# Timestamp-Ordered Two-Input Merge Node

This block joins two streams of flits into one. Each stream carries packets. Every flit of a packet carries the packet's injection timestamp, the ID of its initiator and an end-of-packet marker. When the node has no packet in flight, it compares the timestamps at the heads of its two inputs and grants the older packet. It then passes that whole packet through before it looks at the inputs again. If only one input is waiting, that input is granted at once, so an idle input never costs a cycle.

The node is meant to be tiled as a binary tree. A tree of n-1 nodes funnels n initiators into a single target in first-come-first-served order, and no central arbiter is needed. A build parameter places a small FIFO at the node's output to break long wires. The same parameter can leave the FIFO out, so that the grant decision reaches the output in the same cycle. Valid/ready handshakes carry back-pressure from the target towards the leaves.

Top module: `ts_merge_node`

## Requirements
- R1: When no packet is in flight and both inputs present a head flit, the input whose timestamp is strictly older is granted. The grant shows as that input's ready, and its flit appears at the output.
- R2: When the two head timestamps are equal, input 0 is granted.
- R3: Timestamps are compared modulo 2^TS_W. A timestamp a is older than b when (a - b) mod 2^TS_W has its top bit set. With TS_W=8, 250 counts as older than 3.
- R4: Once the first non-last flit of a packet has been accepted, the other input sees ready low until the last flit of that packet has been accepted.
- R5: At most one flit per cycle crosses the node. The data, ID, timestamp and last marker reach the output unchanged.
- R6: If only one input is valid and no packet is in flight, that input is forwarded without waiting for the other input. Without the output buffer this happens in the same cycle.
- R7: With USE_BUF=1, flits pass through a FIFO of BUF_DEPTH entries. A flit becomes visible at the output no earlier than one cycle after it is accepted. Up to BUF_DEPTH flits are held under a stall, in order, and the output is stable while stalled.
- R8: Back-pressure propagates upstream. Without the buffer, out_ready low drops both input readies. With the buffer, a full FIFO drops both input readies.
- R9: After reset, out_valid is low and no packet is in flight.
- R10: In a tree of such nodes, the root emits every packet contiguously with its flits in order. It loses no packet and keeps each initiator's packets in their issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_valid | input | 1 | Input 0 flit valid |
| in0_ready | output | 1 | Input 0 flit accepted |
| in0_data | input | DATA_W | Input 0 payload |
| in0_id | input | ID_W | Input 0 initiator ID |
| in0_ts | input | TS_W | Input 0 packet timestamp |
| in0_last | input | 1 | Input 0 end-of-packet marker |
| in1_valid | input | 1 | Input 1 flit valid |
| in1_ready | output | 1 | Input 1 flit accepted |
| in1_data | input | DATA_W | Input 1 payload |
| in1_id | input | ID_W | Input 1 initiator ID |
| in1_ts | input | TS_W | Input 1 packet timestamp |
| in1_last | input | 1 | Input 1 end-of-packet marker |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Output flit accepted downstream |
| out_data | output | DATA_W | Output payload |
| out_id | output | ID_W | Output initiator ID |
| out_ts | output | TS_W | Output packet timestamp |
| out_last | output | 1 | Output end-of-packet marker |

## Verification
The bench builds the node in three forms. The first has USE_BUF=0, so every grant decision can be read combinationally in the cycle it is made; this is used for the age, tie, wraparound and stall vectors and for the packet-lock sequence. The second has USE_BUF=1 with BUF_DEPTH=2, which exposes the one-cycle buffer latency and the full-FIFO stall. The third is three buffered nodes wired as a four-leaf tree with random stalls at the root. TS_W=8 keeps the counter wraparound within reach of small timestamp values.

// File: rtl/ts_merge_pkg.sv
package ts_merge_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_IN0  = 2'd1,
    OWN_IN1  = 2'd2
  } own_e;

  // Operands arrive left-aligned in 32 bits so the sign of the difference
  // is the wrap-aware "a is older than b" bit for any TS_W below 32.
  function automatic logic ts_not_after(logic [31:0] a_al, logic [31:0] b_al);
    logic [31:0] diff;
    diff = a_al - b_al;
    return diff[31] || (diff == 32'd0);
  endfunction

endpackage

// File: rtl/ts_merge_fifo.sv
module ts_merge_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pop;

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!push && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_data;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R7
  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

endmodule

// File: rtl/ts_merge_arb.sv
module ts_merge_arb
  import ts_merge_pkg::*;
#(
  parameter int TS_W   = 8,
  parameter int FLIT_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in0_valid,
  output logic              in0_ready,
  input  logic [FLIT_W-1:0] in0_flit,
  input  logic              in1_valid,
  output logic              in1_ready,
  input  logic [FLIT_W-1:0] in1_flit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit
);
  // flit layout: {data, id, ts, last}; ts sits just above the last bit
  localparam int PAD = 32 - TS_W;

  own_e        own_q, own_d;
  logic        sel0, sel1, pick0, fire, last_bit;
  logic [31:0] ts0_al, ts1_al;

  assign ts0_al = {in0_flit[TS_W:1], {PAD{1'b0}}};
  assign ts1_al = {in1_flit[TS_W:1], {PAD{1'b0}}};
  assign pick0  = ts_not_after(ts0_al, ts1_al);

  always_comb begin
    sel0 = 1'b0;
    sel1 = 1'b0;
    unique case (own_q)
      OWN_IN0: sel0 = 1'b1;
      OWN_IN1: sel1 = 1'b1;
      default: begin
        sel0 = in0_valid && (!in1_valid || pick0);
        sel1 = in1_valid && !sel0;
      end
    endcase
  end

  assign out_valid = (sel0 && in0_valid) || (sel1 && in1_valid);
  assign out_flit  = sel1 ? in1_flit : in0_flit;
  assign in0_ready = sel0 && out_ready;
  assign in1_ready = sel1 && out_ready;
  assign fire      = out_valid && out_ready;
  assign last_bit  = out_flit[0];

  always_comb begin
    own_d = own_q;
    if (fire) own_d = last_bit ? OWN_NONE : (sel1 ? OWN_IN1 : OWN_IN0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    own_q <= OWN_NONE;
    else if (fire) own_q <= own_d;
  end

  AST_ONE_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in0_valid && in0_ready, in1_valid && in1_ready})); // R5
  AST_OLDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_NONE && in0_valid && in1_valid && in1_ready)
      |-> !ts_not_after(ts0_al, ts1_al)); // R1
  AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_NONE && (in0_valid || in1_valid)) |-> out_valid); // R6
  AST_LOCK_IN0: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_valid && in0_ready && !in0_flit[0]) |=> !in1_ready); // R4
  AST_LOCK_IN1: assert property (@(posedge clk) disable iff (!rst_n)
    (in1_valid && in1_ready && !in1_flit[0]) |=> !in0_ready); // R4
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (!in0_ready && !in1_ready)); // R8

endmodule

// File: rtl/ts_merge_node.sv
module ts_merge_node #(
  parameter int DATA_W    = 16,
  parameter int ID_W      = 2,
  parameter int TS_W      = 8,
  parameter bit USE_BUF   = 1'b1,
  parameter int BUF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in0_valid,
  output logic              in0_ready,
  input  logic [DATA_W-1:0] in0_data,
  input  logic [ID_W-1:0]   in0_id,
  input  logic [TS_W-1:0]   in0_ts,
  input  logic              in0_last,
  input  logic              in1_valid,
  output logic              in1_ready,
  input  logic [DATA_W-1:0] in1_data,
  input  logic [ID_W-1:0]   in1_id,
  input  logic [TS_W-1:0]   in1_ts,
  input  logic              in1_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ID_W-1:0]   out_id,
  output logic [TS_W-1:0]   out_ts,
  output logic              out_last
);
  localparam int FLIT_W = DATA_W + ID_W + TS_W + 1;

  logic [FLIT_W-1:0] f0, f1, arb_flit, fin_flit;
  logic              arb_valid, arb_ready;

  assign f0 = {in0_data, in0_id, in0_ts, in0_last};
  assign f1 = {in1_data, in1_id, in1_ts, in1_last};

  ts_merge_arb #(.TS_W(TS_W), .FLIT_W(FLIT_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_ready(in0_ready), .in0_flit(f0),
    .in1_valid(in1_valid), .in1_ready(in1_ready), .in1_flit(f1),
    .out_valid(arb_valid), .out_ready(arb_ready), .out_flit(arb_flit)
  );

  generate
    if (USE_BUF) begin : g_buf
      ts_merge_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_valid(arb_valid), .in_ready(arb_ready), .in_data(arb_flit),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(fin_flit)
      );
    end else begin : g_bypass
      assign out_valid = arb_valid;
      assign arb_ready = out_ready;
      assign fin_flit  = arb_flit;
    end
  endgenerate

  assign {out_data, out_id, out_ts, out_last} = fin_flit;

endmodule

// File: tb/ts_merge_node_bench.sv
module ts_merge_node_bench;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int TW = 8;
  localparam int K  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bypass node ----------------
  logic b0v, b0r, b0l, b1v, b1r, b1l, bov, bor, bol;
  logic [DW-1:0] b0d, b1d, bod;
  logic [IW-1:0] b0i, b1i, boi;
  logic [TW-1:0] b0t, b1t, bot;

  ts_merge_node #(.DATA_W(DW), .ID_W(IW), .TS_W(TW), .USE_BUF(1'b0), .BUF_DEPTH(2))
  u_ts_merge_node (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(b0v), .in0_ready(b0r), .in0_data(b0d), .in0_id(b0i), .in0_ts(b0t), .in0_last(b0l),
    .in1_valid(b1v), .in1_ready(b1r), .in1_data(b1d), .in1_id(b1i), .in1_ts(b1t), .in1_last(b1l),
    .out_valid(bov), .out_ready(bor), .out_data(bod), .out_id(boi), .out_ts(bot), .out_last(bol)
  );

  // ---------------- buffered node ----------------
  logic q0v, q0r, q0l, q1r, qov, qor, qol;
  logic [DW-1:0] q0d, qod;
  logic [IW-1:0] qoi;
  logic [TW-1:0] q0t, qot;

  ts_merge_node #(.DATA_W(DW), .ID_W(IW), .TS_W(TW), .USE_BUF(1'b1), .BUF_DEPTH(2))
  u_buf_node (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(q0v), .in0_ready(q0r), .in0_data(q0d), .in0_id(2'd0), .in0_ts(q0t), .in0_last(q0l),
    .in1_valid(1'b0), .in1_ready(q1r), .in1_data('0), .in1_id(2'd1), .in1_ts('0), .in1_last(1'b0),
    .out_valid(qov), .out_ready(qor), .out_data(qod), .out_id(qoi), .out_ts(qot), .out_last(qol)
  );

  // ---------------- four-leaf tree ----------------
  logic          lv [4];
  logic          lr [4];
  logic          ll [4];
  logic [DW-1:0] ld [4];
  logic [TW-1:0] lt [4];
  logic          mv [2];
  logic          mr [2];
  logic          ml [2];
  logic [DW-1:0] md [2];
  logic [IW-1:0] mi [2];
  logic [TW-1:0] mt [2];
  logic          rv, rr, rl;
  logic [DW-1:0] rd;
  logic [IW-1:0] ri;
  logic [TW-1:0] rt;

  for (genvar g = 0; g < 2; g++) begin : g_lvl1
    ts_merge_node #(.DATA_W(DW), .ID_W(IW), .TS_W(TW), .USE_BUF(1'b1), .BUF_DEPTH(2)) u_leafpair (
      .clk(clk), .rst_n(rst_n),
      .in0_valid(lv[2*g]), .in0_ready(lr[2*g]), .in0_data(ld[2*g]), .in0_id(IW'(2*g)),
      .in0_ts(lt[2*g]), .in0_last(ll[2*g]),
      .in1_valid(lv[2*g+1]), .in1_ready(lr[2*g+1]), .in1_data(ld[2*g+1]), .in1_id(IW'(2*g+1)),
      .in1_ts(lt[2*g+1]), .in1_last(ll[2*g+1]),
      .out_valid(mv[g]), .out_ready(mr[g]), .out_data(md[g]), .out_id(mi[g]),
      .out_ts(mt[g]), .out_last(ml[g])
    );
  end

  ts_merge_node #(.DATA_W(DW), .ID_W(IW), .TS_W(TW), .USE_BUF(1'b1), .BUF_DEPTH(2)) u_root (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(mv[0]), .in0_ready(mr[0]), .in0_data(md[0]), .in0_id(mi[0]), .in0_ts(mt[0]), .in0_last(ml[0]),
    .in1_valid(mv[1]), .in1_ready(mr[1]), .in1_data(md[1]), .in1_id(mi[1]), .in1_ts(mt[1]), .in1_last(ml[1]),
    .out_valid(rv), .out_ready(rr), .out_data(rd), .out_id(ri), .out_ts(rt), .out_last(rl)
  );

  // Vector: {v0, ts0[8], v1, ts1[8], out_ready, exp_valid, exp_r0, exp_r1, exp_ts[8]}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'd10,  1'b1, 8'd20,  1'b1, 1'b1, 1'b1, 1'b0, 8'd10},  // R1 in0 older
    {1'b1, 8'd30,  1'b1, 8'd5,   1'b1, 1'b1, 1'b0, 1'b1, 8'd5},   // R1 in1 older
    {1'b1, 8'd7,   1'b1, 8'd7,   1'b1, 1'b1, 1'b1, 1'b0, 8'd7},   // R2 tie
    {1'b1, 8'd250, 1'b1, 8'd3,   1'b1, 1'b1, 1'b1, 1'b0, 8'd250}, // R3 wrap, in0 older
    {1'b1, 8'd3,   1'b1, 8'd250, 1'b1, 1'b1, 1'b0, 1'b1, 8'd250}, // R3 wrap, in1 older
    {1'b1, 8'd128, 1'b1, 8'd1,   1'b1, 1'b1, 1'b0, 1'b1, 8'd1},   // R3 half-range edge
    {1'b0, 8'd1,   1'b1, 8'd99,  1'b1, 1'b1, 1'b0, 1'b1, 8'd99},  // R6 only in1
    {1'b1, 8'd200, 1'b0, 8'd0,   1'b1, 1'b1, 1'b1, 1'b0, 8'd200}, // R6 only in0
    {1'b1, 8'd40,  1'b1, 8'd41,  1'b0, 1'b1, 1'b0, 1'b0, 8'd40},  // R8 stalled
    {1'b0, 8'd40,  1'b0, 8'd41,  1'b1, 1'b0, 1'b0, 1'b0, 8'd0}    // R6 idle
  };

  function automatic int plen(int leaf, int pk);
    return 1 + ((leaf + pk) % 3);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    b0v = 0; b1v = 0; bor = 0; b0d = '0; b1d = '0; b0i = 2'd0; b1i = 2'd1;
    b0t = '0; b1t = '0; b0l = 1; b1l = 1;
    q0v = 0; q0d = '0; q0t = '0; q0l = 1; qor = 0; rr = 0;
    for (int i = 0; i < 4; i++) begin
      lv[i] = 0; ll[i] = 0; ld[i] = '0; lt[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    #1;
    check(!bov && !qov && !rv, "R9 out_valid in reset", {bov, qov, rv}, 0);
    rst_n = 1'b1;

    // ---- table walk on the bypass node, single-flit packets ----
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      b0v = VEC[v][29]; b0t = VEC[v][28:21]; b1v = VEC[v][20]; b1t = VEC[v][19:12];
      bor = VEC[v][11];
      b0d = 16'h1000 + 16'(v); b1d = 16'h2000 + 16'(v); b0l = 1; b1l = 1;
      #1;
      check(bov == VEC[v][10] && b0r == VEC[v][9] && b1r == VEC[v][8] &&
            (!VEC[v][10] || bot == VEC[v][7:0]),
            $sformatf("R1/R2/R3/R6/R8 vector %0d", v),
            {bov, b0r, b1r, bot}, {VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]});
    end

    // R5: sideband passes unchanged
    @(negedge clk);
    b0v = 0; b1v = 1; b1d = 16'hBEEF; b1i = 2'd3; b1t = 8'd77; b1l = 1; bor = 1;
    #1;
    check(bov && bod == 16'hBEEF && boi == 2'd3 && bot == 8'd77 && bol,
          "R5 sideband", {bod, boi, bot}, {16'hBEEF, 2'd3, 8'd77});

    // R4: packet lock on in0 against an older in1 head
    @(negedge clk);
    b1v = 0; b1i = 2'd1; b0v = 1; b0t = 8'd50; b0l = 0; b0d = 16'h0A01; bor = 1;
    #1;
    check(b0r, "R4 first flit granted", b0r, 1);
    @(negedge clk);
    b0d = 16'h0A02; b1v = 1; b1t = 8'd10; b1l = 1;
    #1;
    check(!b1r && b0r && bot == 8'd50, "R4 lock holds mid-packet", {b1r, bot}, {1'b0, 8'd50});
    @(negedge clk);
    b0d = 16'h0A03; b0l = 1;
    #1;
    check(!b1r && b0r && bol, "R4 lock holds at last flit", b1r, 0);
    @(negedge clk);
    b0v = 0;
    #1;
    check(b1r && bot == 8'd10, "R4 released after last flit", {b1r, bot}, {1'b1, 8'd10});
    @(negedge clk);
    b1v = 0;

    // R7: buffered node latency, capacity, order
    q0v = 1; q0d = 16'h00A1; q0t = 8'd9; q0l = 1; qor = 0;
    #1;
    check(!qov, "R7 no same-cycle output", qov, 0);
    @(negedge clk);
    q0d = 16'h00A2; q0t = 8'd10;
    #1;
    check(qov && qot == 8'd9, "R7 visible after one cycle", qot, 9);
    @(negedge clk);
    q0d = 16'h00A3;
    #1;
    check(!q0r && qov && qod == 16'h00A1, "R8 full buffer stalls input", {q0r, qod}, {1'b0, 16'h00A1});
    q0v = 0; qor = 1;
    @(negedge clk);
    #1;
    check(qov && qod == 16'h00A2, "R7 second entry in order", qod, 16'h00A2);
    @(negedge clk);
    #1;
    check(!qov, "R7 buffer drained", qov, 0);
    qor = 0;

    // R10: tree with random root stalls
    begin
      int pk [4];
      int fl [4];
      bit st [4];
      int exp_pk [4];
      int cur_leaf, cur_fl, delivered, iter;
      bit pkt_ok;
      cur_leaf = -1; cur_fl = 0; delivered = 0; iter = 0; pkt_ok = 1;
      for (int i = 0; i < 4; i++) begin
        pk[i] = 0; fl[i] = 0; st[i] = 0; exp_pk[i] = 0;
      end
      while (delivered < 4 * K && iter < 5000) begin
        @(negedge clk);
        iter++;
        rr = ($urandom % 4) != 0;
        for (int i = 0; i < 4; i++) begin
          if (pk[i] < K) begin
            if (!st[i]) begin
              lt[i] = TW'(cyc);
              st[i] = 1;
            end
            lv[i] = 1;
            ld[i] = {2'(i), 6'(pk[i]), 8'(fl[i])};
            ll[i] = (fl[i] == plen(i, pk[i]) - 1);
          end else begin
            lv[i] = 0;
          end
        end
        #1;
        if (rv && rr) begin
          int lf, p, f;
          lf = int'(rd[15:14]); p = int'(rd[13:8]); f = int'(rd[7:0]);
          if (cur_leaf < 0) begin
            if (f != 0 || p != exp_pk[lf] || int'(ri) != lf) pkt_ok = 0;
            cur_leaf = lf; cur_fl = 0;
          end else begin
            if (lf != cur_leaf || f != cur_fl + 1) pkt_ok = 0;
            cur_fl = f;
          end
          if (rl) begin
            if (f != plen(lf, p) - 1) pkt_ok = 0;
            check(pkt_ok, $sformatf("R10 packet leaf %0d", lf), {16'(p), 16'(f)},
                  {16'(exp_pk[lf]), 16'(plen(lf, exp_pk[lf]) - 1)});
            exp_pk[lf]++;
            delivered++;
            cur_leaf = -1;
            pkt_ok = 1;
          end
        end
        for (int i = 0; i < 4; i++) begin
          if (lv[i] && lr[i]) begin
            if (ll[i]) begin
              pk[i]++; fl[i] = 0; st[i] = 0;
            end else begin
              fl[i]++;
            end
          end
        end
      end
      check(delivered == 4 * K, "R10 all packets delivered", delivered, 4 * K);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule